// File: doc/BRIEF.md
# Multi-Source Warm Reset Sequencer

This block turns three reset causes into one timed reset sequence. The causes are a cold reset from the external pin or power-on, a reset written by software, and an underflow of the watchdog. While a sequence runs, the block holds the CPU and the peripheral registers in reset and forces every port pin into input mode. The sequence lasts a fixed number of clock cycles. When it ends, the block gives a one-cycle strobe that tells the CPU to load its start address from a fixed vector location.

A software request is taken only when the main clock drives the CPU and its oscillation is flagged stable. Under any other clock condition the request is dropped. A watchdog underflow starts a reset only when the watchdog-reset enable is set. When the enable is clear, the underflow gives a one-cycle interrupt pulse instead.

A small group of retained register bits keeps its value through the warm resets (software and watchdog) and is cleared only by a cold reset. These are the processor-mode bits, one watchdog control bit and a protection byte. A cause register records in one-hot form which source started the last reset. The cause register is also cleared only by a cold reset.

Top module: `rst_sequencer`

## Requirements
- R1: While ext_rst_n is low, the block asserts its outputs asynchronously: cpu_rst_n = 0, periph_rst_n = 0, all bits of pin_force_in = 1, rst_cause = 3'b001 (cold) and ret_q = 0.
- R2: After ext_rst_n rises, cpu_rst_n and periph_rst_n rise at the (SYNC_STAGES + HOLD_CYCLES)-th rising clock edge. This is edge 18 with the default values.
- R3: A sw_rst_req high at an edge with clk_main_sel = 1 and clk_main_stable = 1 starts a reset. cpu_rst_n and periph_rst_n go low after that edge and stay low for exactly HOLD_CYCLES cycles. rst_cause becomes 3'b010 (software).
- R4: A sw_rst_req made while clk_main_sel = 0 or clk_main_stable = 0 has no effect. No reset starts, and rst_cause and ret_q keep their values.
- R5: A wdog_unf high at an edge with wdog_rst_en = 1 starts the same timed reset, and rst_cause becomes 3'b100 (watchdog).
- R6: A wdog_unf high at an edge with wdog_rst_en = 0 starts no reset. wdog_irq goes high for exactly the one following cycle, unless a valid software request is taken at the same edge.
- R7: Every bit of pin_force_in is 1 in every cycle in which cpu_rst_n is low.
- R8: vec_fetch is high for exactly one cycle, the first cycle in which cpu_rst_n is high after a reset. vec_addr always equals RESET_VECTOR (24'hFFFFFC by default).
- R9: ret_q is loaded from ret_wr_data at an edge where ret_wr_en = 1 and no reset is active. It keeps its value through software and watchdog resets. Writes made while a reset is active are ignored.
- R10: When both are taken at the same edge, the watchdog wins over software and rst_cause = 3'b100. A cold reset overrides a running warm reset at once: rst_cause = 3'b001 and ret_q = 0.
- R11: Software or watchdog triggers that arrive while a reset is active are ignored. The reset is not extended and rst_cause is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| ext_rst_n | input | 1 | Cold reset from pin or power-on, active low, asynchronous |
| sw_rst_req | input | 1 | Software writes 1 to request a reset |
| clk_main_sel | input | 1 | Main clock is the CPU clock source |
| clk_main_stable | input | 1 | Main oscillator is flagged stable |
| wdog_unf | input | 1 | Watchdog underflow strobe |
| wdog_rst_en | input | 1 | 1: an underflow resets the system; 0: an underflow raises an interrupt |
| ret_wr_en | input | 1 | Write strobe for the retained bits |
| ret_wr_data | input | RET_W | Write data for the retained bits |
| cpu_rst_n | output | 1 | CPU reset, active low |
| periph_rst_n | output | 1 | Peripheral register reset, active low |
| pin_force_in | output | NUM_PINS | Per-pin force-to-input, 1 = input |
| vec_fetch | output | 1 | One-cycle strobe: fetch the start address from the vector |
| vec_addr | output | ADDR_W | Address of the reset vector |
| wdog_irq | output | 1 | Watchdog interrupt pulse |
| rst_cause | output | 3 | One-hot last cause: 001 cold, 010 software, 100 watchdog |
| ret_q | output | RET_W | Retained bits: [1:0] mode, [2] watchdog control, [10:3] protection |

## Verification
The bench builds the block with its default parameters: a hold of 16 cycles, a two-stage synchronizer, two mode bits, an eight-bit protection field and eight pins. With a 16-cycle window, a watchdog trigger can land well inside a running software reset, so the test can show that the release edge does not move. The two-stage synchronizer makes the cold release land at edge 18, which the test counts exactly. The 11-bit retained vector carries a distinct pattern, so the test can tell a retained value from a cleared one and from a write that was ignored during reset.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
   localparam int CAUSE_W = 3;
   localparam logic [CAUSE_W-1:0] CAUSE_COLD = 3'b001;
   localparam logic [CAUSE_W-1:0] CAUSE_SW   = 3'b010;
   localparam logic [CAUSE_W-1:0] CAUSE_WDOG = 3'b100;
endpackage

// File: rtl/rst_cold_sync.sv
module rst_cold_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic async_rst_n,
   output logic sync_rst_n
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("rst_cold_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge async_rst_n) begin
               if (!async_rst_n) chain_q[0] <= 1'b0;
               else              chain_q[0] <= 1'b1;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge async_rst_n) begin
               if (!async_rst_n) chain_q[i] <= 1'b0;
               else              chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign sync_rst_n = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/rst_src_arb.sv
module rst_src_arb
   import rst_seq_pkg::*;
(
   input  logic               busy,
   input  logic               sw_req,
   input  logic               main_sel,
   input  logic               main_stable,
   input  logic               wdog_unf,
   input  logic               wdog_rst_en,
   output logic               start,
   output logic [CAUSE_W-1:0] start_cause,
   output logic               irq_set
);
   logic sw_ok;
   logic wdog_hit;

   always_comb begin
      sw_ok       = sw_req && main_sel && main_stable;
      wdog_hit    = wdog_unf && wdog_rst_en;
      start       = !busy && (wdog_hit || sw_ok);
      start_cause = wdog_hit ? CAUSE_WDOG : CAUSE_SW;
      irq_set     = !busy && wdog_unf && !wdog_rst_en && !sw_ok;
   end
endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
   parameter int HOLD_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active,
   output logic last
);
   generate
      if (HOLD_CYCLES < 2) begin : g_bad_hold
         $error("rst_hold_timer: HOLD_CYCLES must be at least 2");
      end
   endgenerate

   localparam int CNT_W = $clog2(HOLD_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b1;
         cnt_q  <= '0;
      end else if (active) begin
         if (cnt_q == CNT_LAST) begin
            active <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (start) begin
         active <= 1'b1;
         cnt_q  <= '0;
      end
   end

   assign last = active && (cnt_q == CNT_LAST);

   // R3
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !last) |=> active);
endmodule

// File: rtl/rst_keep_regs.sv
module rst_keep_regs
   import rst_seq_pkg::*;
#(
   parameter int RET_W = 11
) (
   input  logic               clk,
   input  logic               cold_rst_n,
   input  logic               busy,
   input  logic               wr_en,
   input  logic [RET_W-1:0]   wr_data,
   input  logic               start,
   input  logic [CAUSE_W-1:0] start_cause,
   output logic [RET_W-1:0]   ret_q,
   output logic [CAUSE_W-1:0] cause_q
);
   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n) ret_q <= '0;
      else if (wr_en && !busy) ret_q <= wr_data;
   end

   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n) cause_q <= CAUSE_COLD;
      else if (start)  cause_q <= start_cause;
   end

   // R9
   keep_in_reset_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
      busy |=> $stable(ret_q));

   // R10
   cause_onehot_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
      $countones(cause_q) == 1);
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
   import rst_seq_pkg::*;
#(
   parameter int              HOLD_CYCLES  = 16,
   parameter int              SYNC_STAGES  = 2,
   parameter int              MODE_W       = 2,
   parameter int              PROT_W       = 8,
   parameter int              NUM_PINS     = 8,
   parameter int              ADDR_W       = 24,
   parameter logic [ADDR_W-1:0] RESET_VECTOR = 24'hFFFFFC,
   localparam int             RET_W        = MODE_W + 1 + PROT_W
) (
   input  logic                clk,
   input  logic                ext_rst_n,
   input  logic                sw_rst_req,
   input  logic                clk_main_sel,
   input  logic                clk_main_stable,
   input  logic                wdog_unf,
   input  logic                wdog_rst_en,
   input  logic                ret_wr_en,
   input  logic [RET_W-1:0]    ret_wr_data,
   output logic                cpu_rst_n,
   output logic                periph_rst_n,
   output logic [NUM_PINS-1:0] pin_force_in,
   output logic                vec_fetch,
   output logic [ADDR_W-1:0]   vec_addr,
   output logic                wdog_irq,
   output logic [CAUSE_W-1:0]  rst_cause,
   output logic [RET_W-1:0]    ret_q
);
   generate
      if (MODE_W < 1 || PROT_W < 1 || NUM_PINS < 1) begin : g_bad_widths
         $error("rst_sequencer: field widths and pin count must be positive");
      end
   endgenerate

   logic               cold_n;
   logic               active;
   logic               hold_last;
   logic               start;
   logic [CAUSE_W-1:0] start_cause;
   logic               irq_set;

   rst_cold_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .async_rst_n (ext_rst_n),
      .sync_rst_n  (cold_n)
   );

   rst_src_arb u_arb (
      .busy        (active),
      .sw_req      (sw_rst_req),
      .main_sel    (clk_main_sel),
      .main_stable (clk_main_stable),
      .wdog_unf    (wdog_unf),
      .wdog_rst_en (wdog_rst_en),
      .start       (start),
      .start_cause (start_cause),
      .irq_set     (irq_set)
   );

   rst_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk    (clk),
      .rst_n  (cold_n),
      .start  (start),
      .active (active),
      .last   (hold_last)
   );

   rst_keep_regs #(.RET_W(RET_W)) u_keep (
      .clk         (clk),
      .cold_rst_n  (cold_n),
      .busy        (active),
      .wr_en       (ret_wr_en),
      .wr_data     (ret_wr_data),
      .start       (start),
      .start_cause (start_cause),
      .ret_q       (ret_q),
      .cause_q     (rst_cause)
   );

   always_ff @(posedge clk or negedge cold_n) begin
      if (!cold_n) begin
         vec_fetch <= 1'b0;
         wdog_irq  <= 1'b0;
      end else begin
         vec_fetch <= hold_last;
         wdog_irq  <= irq_set;
      end
   end

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         assign pin_force_in[p] = active;
      end
   endgenerate

   assign cpu_rst_n    = !active;
   assign periph_rst_n = !active;
   assign vec_addr     = RESET_VECTOR;

   // R4
   sw_gate_chk: assert property (@(posedge clk) disable iff (!cold_n)
      (!active && sw_rst_req && !(clk_main_sel && clk_main_stable) && !wdog_unf)
      |=> cpu_rst_n);

   // R6
   wdog_irq_src_chk: assert property (@(posedge clk) disable iff (!cold_n)
      wdog_irq |-> $past(wdog_unf && !wdog_rst_en));

   // R8
   vec_on_release_chk: assert property (@(posedge clk) disable iff (!cold_n)
      $rose(cpu_rst_n) |-> vec_fetch);

   // R6
   wdog_no_rst_chk: assert property (@(posedge clk) disable iff (!cold_n)
      (!active && wdog_unf && !wdog_rst_en && !sw_rst_req) |=> cpu_rst_n);
endmodule

// File: tb/rst_sequencer_tb_top.sv
module rst_sequencer_tb_top;
   localparam int HOLD  = 16;
   localparam int SYNC  = 2;
   localparam int RET_W = 11;
   localparam int NPINS = 8;

   logic             clk = 1'b0;
   logic             ext_rst_n = 1'b0;
   logic             sw_rst_req = 1'b0;
   logic             clk_main_sel = 1'b1;
   logic             clk_main_stable = 1'b1;
   logic             wdog_unf = 1'b0;
   logic             wdog_rst_en = 1'b1;
   logic             ret_wr_en = 1'b0;
   logic [RET_W-1:0] ret_wr_data = '0;
   logic             cpu_rst_n;
   logic             periph_rst_n;
   logic [NPINS-1:0] pin_force_in;
   logic             vec_fetch;
   logic [23:0]      vec_addr;
   logic             wdog_irq;
   logic [2:0]       rst_cause;
   logic [RET_W-1:0] ret_q;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   rst_sequencer dut_i (
      .clk             (clk),
      .ext_rst_n       (ext_rst_n),
      .sw_rst_req      (sw_rst_req),
      .clk_main_sel    (clk_main_sel),
      .clk_main_stable (clk_main_stable),
      .wdog_unf        (wdog_unf),
      .wdog_rst_en     (wdog_rst_en),
      .ret_wr_en       (ret_wr_en),
      .ret_wr_data     (ret_wr_data),
      .cpu_rst_n       (cpu_rst_n),
      .periph_rst_n    (periph_rst_n),
      .pin_force_in    (pin_force_in),
      .vec_fetch       (vec_fetch),
      .vec_addr        (vec_addr),
      .wdog_irq        (wdog_irq),
      .rst_cause       (rst_cause),
      .ret_q           (ret_q)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Wait from the drive negedge until cpu_rst_n is high; returns negedges waited.
   task automatic wait_release(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
         sw_rst_req = 1'b0;
         wdog_unf   = 1'b0;
         if (!cpu_rst_n) check("R7 pins forced in reset", 32'(pin_force_in), 32'({NPINS{1'b1}}));
      end while (cpu_rst_n !== 1'b1 && n < 100);
   endtask

   task automatic t_cold_start();
      int n;
      repeat (3) @(negedge clk);
      check("R1 cpu_rst_n in cold", 32'(cpu_rst_n), 0);
      check("R1 periph_rst_n in cold", 32'(periph_rst_n), 0);
      check("R1 pins in cold", 32'(pin_force_in), 32'({NPINS{1'b1}}));
      check("R1 cause in cold", 32'(rst_cause), 32'h1);
      check("R1 ret_q in cold", 32'(ret_q), 0);
      ext_rst_n = 1'b1;
      wait_release(n);
      check("R2 cold release edge", n, SYNC + HOLD);
      check("R8 vec_fetch on cold release", 32'(vec_fetch), 1);
      check("R8 vec_addr", 32'(vec_addr), 32'hFFFFFC);
      @(negedge clk);
      check("R8 vec_fetch one cycle", 32'(vec_fetch), 0);
   endtask

   task automatic t_sw_ok();
      int n;
      ret_wr_en = 1'b1; ret_wr_data = 11'h5A3;
      @(negedge clk);
      ret_wr_en = 1'b0;
      check("R9 ret write", 32'(ret_q), 32'h5A3);
      sw_rst_req = 1'b1;
      @(negedge clk);
      sw_rst_req = 1'b0;
      check("R3 sw reset asserted", 32'(cpu_rst_n), 0);
      check("R3 periph reset asserted", 32'(periph_rst_n), 0);
      check("R3 cause sw", 32'(rst_cause), 32'h2);
      wait_release(n);
      check("R3 sw hold length", n + 1, HOLD + 1);
      check("R8 vec_fetch after sw", 32'(vec_fetch), 1);
      check("R9 ret kept over sw reset", 32'(ret_q), 32'h5A3);
      @(negedge clk);
      check("R8 vec_fetch drops", 32'(vec_fetch), 0);
   endtask

   task automatic t_sw_gated(input logic sel, input logic stab);
      logic [2:0] c0;
      c0 = rst_cause;
      clk_main_sel = sel; clk_main_stable = stab; sw_rst_req = 1'b1;
      @(negedge clk);
      sw_rst_req = 1'b0;
      repeat (2) @(negedge clk);
      check("R4 gated sw no reset", 32'(cpu_rst_n), 1);
      check("R4 gated sw cause kept", 32'(rst_cause), 32'(c0));
      check("R4 gated sw ret kept", 32'(ret_q), 32'h5A3);
      clk_main_sel = 1'b1; clk_main_stable = 1'b1;
   endtask

   task automatic t_wdog_rst();
      int n;
      wdog_rst_en = 1'b1; wdog_unf = 1'b1;
      @(negedge clk);
      wdog_unf = 1'b0;
      check("R5 wdog reset asserted", 32'(cpu_rst_n), 0);
      check("R5 cause wdog", 32'(rst_cause), 32'h4);
      wait_release(n);
      check("R5 wdog hold length", n + 1, HOLD + 1);
      check("R9 ret kept over wdog", 32'(ret_q), 32'h5A3);
   endtask

   task automatic t_wdog_irq();
      logic [2:0] c0;
      c0 = rst_cause;
      wdog_rst_en = 1'b0; wdog_unf = 1'b1;
      @(negedge clk);
      wdog_unf = 1'b0;
      check("R6 irq pulse", 32'(wdog_irq), 1);
      check("R6 no reset", 32'(cpu_rst_n), 1);
      @(negedge clk);
      check("R6 irq one cycle", 32'(wdog_irq), 0);
      check("R6 cause kept", 32'(rst_cause), 32'(c0));
      wdog_rst_en = 1'b1;
   endtask

   task automatic t_priority();
      int n;
      sw_rst_req = 1'b1; wdog_unf = 1'b1; wdog_rst_en = 1'b1;
      @(negedge clk);
      sw_rst_req = 1'b0; wdog_unf = 1'b0;
      check("R10 wdog over sw", 32'(rst_cause), 32'h4);
      wait_release(n);
   endtask

   task automatic t_retrigger();
      int n;
      sw_rst_req = 1'b1;
      @(negedge clk);
      sw_rst_req = 1'b0;
      repeat (4) @(negedge clk);
      wdog_unf = 1'b1; ret_wr_en = 1'b1; ret_wr_data = 11'h0F0;
      @(negedge clk);
      wdog_unf = 1'b0; ret_wr_en = 1'b0;
      check("R11 cause not changed", 32'(rst_cause), 32'h2);
      wait_release(n);
      check("R11 hold not extended", n + 6, HOLD + 1);
      check("R9 write in reset ignored", 32'(ret_q), 32'h5A3);
   endtask

   task automatic t_cold_over_warm();
      int n;
      sw_rst_req = 1'b1;
      @(negedge clk);
      sw_rst_req = 1'b0;
      repeat (3) @(negedge clk);
      ext_rst_n = 1'b0;
      #1;
      check("R10 cold overrides cause", 32'(rst_cause), 32'h1);
      check("R10 cold clears ret", 32'(ret_q), 0);
      @(negedge clk);
      ext_rst_n = 1'b1;
      wait_release(n);
      check("R2 release after cold override", n, SYNC + HOLD);
      check("R1 cause cold after release", 32'(rst_cause), 32'h1);
   endtask

   initial begin
      t_cold_start();
      t_sw_ok();
      t_sw_gated(1'b0, 1'b1);
      t_sw_gated(1'b1, 1'b0);
      t_wdog_rst();
      t_wdog_irq();
      t_priority();
      t_retrigger();
      t_cold_over_warm();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #800000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule